// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block maps a byte position inside a two-dimensional surface, given as a byte column and a row, to the byte offset where that position is stored in the backing memory. The surface is either linear or split into 4 KiB tiles of one of three shapes. A tile may be 512 bytes wide by 8 rows, 128 bytes wide by 32 rows, or 64 by 64 bytes. In the last shape the bytes are nested as 8x8, 4x4, 2x2 and single-byte sub-blocks. An optional swizzle folds higher offset bits into bit 6, which matches memory controllers that interleave channels on that bit.

The generator is fully pipelined. It accepts one request per cycle and returns each result exactly two cycles later with a matching valid strobe. A texture copy or conversion engine walks a box of pixels and feeds one coordinate per cycle into it. Surface origin computation and memory access are handled elsewhere.

Top module: `tile_addr_gen`

## Requirements
- R1: With layout code 0 (linear), the offset is row × pitch + column.
- R2: With layout code 1, tiles are 512 bytes by 8 rows and the tile count per row is pitch/512. The tile number is (row/8) × that count + column/512. The offset is tile × 4096 + (row mod 8) × 512 + (column mod 512).
- R3: With layout code 2, tiles are 128 bytes by 32 rows and the tile count per row is pitch/128. Inside a tile, 16-byte units are numbered column-first: unit = ((column mod 128)/16) × 32 + (row mod 32). The offset is tile × 4096 + unit × 16 + (column mod 16).
- R4: With layout code 3, tiles are 64 by 64 bytes and the tile count per row is pitch/64. The 8x8 block index is ((column/8) mod 8) × 8 + ((row/8) mod 8). The sub-block index at level k is row bit k × 2 + column bit k, for k = 2, 1, 0. The offset is tile × 4096 + blk8 × 64 + blk4 × 16 + blk2 × 4 + blk1.
- R5: With swizzle enabled in layout 1, offset bit 6 becomes bit6 XOR bit9 XOR bit10 of the unswizzled offset.
- R6: With swizzle enabled in layouts 2 and 3, offset bit 6 becomes bit6 XOR bit9 of the unswizzled offset.
- R7: In the linear layout the swizzle enable has no effect on the offset.
- R8: A request presented with in_valid before clock edge n gives out_valid and its offset after edge n+2. Requests may arrive on consecutive cycles, and out_valid is low two cycles after an idle cycle.
- R9: While rst_n is low and until the first request has crossed the pipeline, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request strobe |
| mem_x | input | CW (16) | Byte column |
| mem_y | input | CW (16) | Row |
| pitch | input | PW (16) | Surface row pitch in bytes, a multiple of the tile width |
| mode | input | 2 | Layout: 0 linear, 1 512x8, 2 128x32, 3 64x64 |
| swz_en | input | 1 | Bit-6 swizzle enable |
| out_valid | output | 1 | Result strobe |
| offset | output | OW (32) | Byte offset |

## Verification
The hardest case to reach is a coordinate that crosses several tile boundaries at once while bits 9 and 10 of the offset differ. Only then does the swizzle produce a value that is distinct from both the plain offset and a single-term XOR. The stimulus sweeps columns with a stride that is prime to every tile width, past the 512-byte boundary, and rows past the 64-row boundary. It does this for two pitches and both swizzle settings in every layout. It also inserts idle cycles at intervals so that the valid pipeline sees gaps between back-to-back streams.

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int CW = 16,
  parameter int PW = 16,
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] mem_x,
  input  logic [CW-1:0] mem_y,
  input  logic [PW-1:0] pitch,
  input  logic [1:0]    mode,
  input  logic          swz_en,
  output logic          out_valid,
  output logic [OW-1:0] offset
);
  localparam logic [1:0] M_LIN = 2'd0, M_X = 2'd1, M_Y = 2'd2, M_W = 2'd3;
  localparam int TB = 12;

  logic [CW-1:0] row_c, col_c;
  logic [PW-1:0] tpr_c;
  logic [TB-1:0] in_tile, in_swz;

  always_comb begin
    unique case (mode)
      M_X: begin
        row_c = mem_y >> 3; col_c = mem_x >> 9; tpr_c = pitch >> 9;
        in_tile = {mem_y[2:0], mem_x[8:0]};
      end
      M_Y: begin
        row_c = mem_y >> 5; col_c = mem_x >> 7; tpr_c = pitch >> 7;
        in_tile = {mem_x[6:4], mem_y[4:0], mem_x[3:0]};
      end
      M_W: begin
        row_c = mem_y >> 6; col_c = mem_x >> 6; tpr_c = pitch >> 6;
        in_tile = {mem_x[5:3], mem_y[5:3], mem_y[2], mem_x[2],
                   mem_y[1], mem_x[1], mem_y[0], mem_x[0]};
      end
      default: begin
        row_c = mem_y; col_c = mem_x; tpr_c = pitch;
        in_tile = '0;
      end
    endcase
  end

  logic flip;
  assign flip = swz_en && (mode != M_LIN) &&
                (in_tile[9] ^ ((mode == M_X) && in_tile[10]));
  assign in_swz = in_tile ^ (TB'(flip) << 6);

  logic          s1_valid, s1_lin;
  logic [CW-1:0] s1_row, s1_col;
  logic [PW-1:0] s1_tpr;
  logic [TB-1:0] s1_intra;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    s1_lin   <= (mode == M_LIN);
    s1_row   <= row_c;
    s1_col   <= col_c;
    s1_tpr   <= tpr_c;
    s1_intra <= in_swz;
  end

  logic [OW-1:0] base, result;
  assign base   = OW'(s1_row) * OW'(s1_tpr) + OW'(s1_col);
  assign result = s1_lin ? base : {base[OW-TB-1:0], s1_intra};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid;
  end

  always_ff @(posedge clk) offset <= result;
endmodule

module tile_addr_gen_chk #(
  parameter int CW = 16,
  parameter int PW = 16,
  parameter int OW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [CW-1:0] mem_x,
  input logic [CW-1:0] mem_y,
  input logic [PW-1:0] pitch,
  input logic [1:0]    mode,
  input logic          swz_en,
  input logic          out_valid,
  input logic [OW-1:0] offset
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  logic full;
  assign full = (age == 2'd2);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R9
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> out_valid == $past(in_valid, 2)); // R8
  AST_LIN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(in_valid, 2) && $past(mode, 2) == 2'd0) |->
    offset == OW'($past(mem_y, 2)) * OW'($past(pitch, 2)) + OW'($past(mem_x, 2))); // R1
  AST_X_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(in_valid, 2) && $past(mode, 2) == 2'd1 && !$past(swz_en, 2)) |->
    offset[11:0] == {$past(mem_y[2:0], 2), $past(mem_x[8:0], 2)}); // R2
  AST_Y_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(in_valid, 2) && $past(mode, 2) == 2'd2) |->
    (offset[3:0] == $past(mem_x[3:0], 2) && offset[5:4] == $past(mem_y[1:0], 2))); // R3
  AST_W_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(in_valid, 2) && $past(mode, 2) == 2'd3) |->
    (offset[0] == $past(mem_x[0], 2) && offset[1] == $past(mem_y[0], 2))); // R4
  AST_X_SWZ: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(in_valid, 2) && $past(mode, 2) == 2'd1 && $past(swz_en, 2)) |->
    offset[6] == ($past(mem_x[6], 2) ^ $past(mem_y[0], 2) ^ $past(mem_y[1], 2))); // R5
  AST_KNOWN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(offset)); // R8
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.CW(CW), .PW(PW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mem_x(mem_x), .mem_y(mem_y),
  .pitch(pitch), .mode(mode), .swz_en(swz_en), .out_valid(out_valid),
  .offset(offset)
);

// File: tb/tb_tile_addr_gen.sv
module tb_tile_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] mem_x = '0, mem_y = '0, pitch = '0;
  logic [1:0]  mode = '0;
  logic        swz_en = 1'b0;
  logic        out_valid;
  logic [31:0] offset;

  tile_addr_gen dut (.*);

  always #10 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  bit done = 0;

  function automatic logic [31:0] model(int x, int y, int p, int m, bit s);
    int t, r, b8, b4, b2, b1;
    bit f;
    case (m)
      0: r = y * p + x;
      1: begin
        t = (y / 8) * (p / 512) + x / 512;
        r = t * 4096 + (y % 8) * 512 + (x % 512);
      end
      2: begin
        t = (y / 32) * (p / 128) + x / 128;
        r = t * 4096 + (((x % 128) / 16) * 32 + (y % 32)) * 16 + (x % 16);
      end
      default: begin
        t  = (y / 64) * (p / 64) + x / 64;
        b8 = ((x / 8) % 8) * 8 + ((y / 8) % 8);
        b4 = ((y / 4) % 2) * 2 + ((x / 4) % 2);
        b2 = ((y / 2) % 2) * 2 + ((x / 2) % 2);
        b1 = (y % 2) * 2 + (x % 2);
        r  = t * 4096 + b8 * 64 + b4 * 16 + b2 * 4 + b1;
      end
    endcase
    if (s && m != 0) begin
      f = ((r / 512) % 2 == 1);
      if (m == 1 && (r / 1024) % 2 == 1) f = !f;
      if (f) r = r ^ 64;
    end
    return 32'(r);
  endfunction

  function automatic string tag(int m, bit s);
    if (m == 0) return s ? "R7" : "R1";
    if (s) return (m == 1) ? "R5" : "R6";
    return (m == 1) ? "R2" : (m == 2) ? "R3" : "R4";
  endfunction

  logic        h1_v = 0, h2_v = 0;
  logic [31:0] h1_e = 0, h2_e = 0;
  string       h1_t = "", h2_t = "";

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic step(bit v, int x, int y, int p, int m, bit s);
    @(negedge clk);
    vectors++;
    if (out_valid !== h2_v) begin
      fails++;
      $display("FAIL R8 out_valid actual %0b expected %0b", out_valid, h2_v);
    end else if (h2_v && offset !== h2_e) begin
      fails++;
      $display("FAIL %s offset actual %0h expected %0h", h2_t, offset, h2_e);
    end
    h2_v = h1_v; h2_e = h1_e; h2_t = h1_t;
    h1_v = v;
    h1_e = v ? model(x, y, p, m, s) : 32'd0;
    h1_t = tag(m, s);
    in_valid = v; mem_x = 16'(x); mem_y = 16'(y); pitch = 16'(p);
    mode = 2'(m); swz_en = s;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int n;
    n = 0;
    repeat (3) begin
      @(negedge clk);
      vectors++;
      if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R9 out_valid in reset actual %0b expected 0", out_valid);
      end
    end
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int pi = 0; pi < 2; pi++)
          for (int y = 0; y < 150; y += 3)
            for (int x = 0; x < 1100; x += 37) begin
              n++;
              if (n % 17 == 0) step(0, 0, 0, 0, 0, 0);
              step(1, x, y, (pi == 0) ? 2048 : 4096, m, s[0]);
            end
    repeat (3) step(0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule